// File: doc/BRIEF.md
# Super-Pixel Hit Packetizer

This block sits behind a 4x4 group of pixel discriminators in a hybrid pixel readout chip. Each discriminator line is asynchronous to the chip. The block brings every line into the 40 MHz bunch clock domain and detects its leading and trailing edges. It measures the charge of each hit as the number of clock cycles the line stays high, and it groups all pixels whose leading edges land in the same bunch crossing into one cluster. That cluster shares a single timestamp taken from a free-running bunch counter.

Two cluster buffers are available. A cluster becomes ready once its bunch crossing has passed and every pixel in it has finished its charge measurement. The block then presents one zero-suppressed packet to the readout bus. The packet is a 28-bit header and a payload of one byte per hit pixel. The request stays up until the bus answers with done, and that answer frees the buffer. Leading edges that find no buffer are dropped and counted.

Top module: `superpixel_packetizer`

## Requirements
- R1: After reset `req_o` is low, `hdr_o` and `payload_o` are zero and `lost_o` is zero.
- R2: The charge value of a hit equals the number of rising clock edges at which the synchronised line is high, starting with the edge that detects the leading edge. A line held high for k clock cycles gives min(k,15), and the value is never 0.
- R3: A charge count that reaches 15 stops counting, and that pixel is treated as finished. Its packet can be requested while its line is still high, and the later trailing edge produces no packet.
- R4: All leading edges detected in the same clock cycle belong to one packet. Its timestamp is the `bxid_i` value present at the third rising clock edge that samples the line high: two synchroniser stages plus edge detection.
- R5: Leading edges detected in different bunch crossings go to different packets, and packets are offered oldest cluster first.
- R6: Header layout: `hdr_o[27:16]` holds the timestamp, `hdr_o[15:4]` holds `sp_addr_i`, and `hdr_o[3:0]` holds the number of hits minus one (0 means one hit, 15 means sixteen).
- R7: Payload layout: the j-th hit occupies `payload_o[8j+7:8j]` as {pixel index[3:0], charge[3:0]}. Hits appear in ascending pixel index, pixels without a hit are left out, and unused payload bits are zero.
- R8: A cluster is not requested while any of its pixels is still measuring charge, that is, while its line is high and its count is below 15.
- R9: While `req_o` is high and `done_i` is low, `req_o`, `hdr_o` and `payload_o` hold their values. `done_i` together with `req_o` frees the buffer. `done_i` while `req_o` is low has no effect.
- R10: At most two clusters are held. A leading edge in a new bunch crossing while both buffers are occupied is dropped, and `lost_o` increases by one for each dropped pixel, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | 16 | Asynchronous discriminator lines, bit p is pixel p |
| bxid_i | input | 12 | Free-running bunch-crossing counter |
| sp_addr_i | input | 12 | Fixed address of this super pixel |
| req_o | output | 1 | A complete packet is offered |
| done_i | input | 1 | Readout has taken the offered packet |
| hdr_o | output | 28 | Packet header: timestamp, address, hit count minus one |
| payload_o | output | 128 | Packed hit bytes, first hit in the low byte |
| lost_o | output | 8 | Saturating count of dropped leading edges |

## Verification
The hardest state to reach is both buffers occupied while a third bunch crossing brings new leading edges. The bench staggers three groups of short pulses two clock cycles apart and withholds done, so that the first two clusters are still waiting when the third arrives. A second hard case is saturation. A line is held high well past fifteen cycles, and the request must be seen to rise before that line falls.

// File: rtl/superpixel_packetizer.sv
module superpixel_packetizer #(
  parameter int NPIX  = 16,
  parameter int TSW   = 12,
  parameter int ADW   = 12,
  parameter int TOTW  = 4,
  parameter int LOSTW = 8,
  localparam int IDXW = $clog2(NPIX),
  localparam int HITW = IDXW + TOTW,
  localparam int HDRW = TSW + ADW + IDXW,
  localparam int PLW  = NPIX * HITW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  disc_i,
  input  logic [TSW-1:0]   bxid_i,
  input  logic [ADW-1:0]   sp_addr_i,
  output logic             req_o,
  input  logic             done_i,
  output logic [HDRW-1:0]  hdr_o,
  output logic [PLW-1:0]   payload_o,
  output logic [LOSTW-1:0] lost_o
);

  localparam logic [TOTW-1:0] TOT_MAX = '1;

  logic [NPIX-1:0] sync1, sync2, sync3;
  logic [NPIX-1:0] rise;
  logic [1:0]      valid, open_b;
  logic [TSW-1:0]  ts  [2];
  logic [NPIX-1:0] hmap[2];
  logic [TOTW-1:0] tot [2][NPIX];
  logic            head, tail;
  logic [NPIX-1:0] active, owner;

  logic            tgt, alloc, slot_ok;
  logic [NPIX-1:0] accept, drop, head_mask;
  logic [IDXW:0]   nhits;
  logic [LOSTW:0]  lost_sum;

  assign rise = sync2 & ~sync3;

  always_comb begin
    slot_ok = 1'b1;
    alloc   = 1'b0;
    tgt     = 1'b0;
    if (valid[0] && open_b[0] && ts[0] == bxid_i) begin
      tgt = 1'b0;
    end else if (valid[1] && open_b[1] && ts[1] == bxid_i) begin
      tgt = 1'b1;
    end else if (!valid[tail]) begin
      tgt   = tail;
      alloc = 1'b1;
    end else begin
      slot_ok = 1'b0;
    end
  end

  assign accept = slot_ok ? (rise & (alloc ? {NPIX{1'b1}} : ~hmap[tgt])) : '0;
  assign drop   = rise & ~accept;

  assign head_mask = head ? owner : ~owner;
  assign req_o     = valid[head] && !open_b[head] && !(|(active & head_mask));

  assign nhits    = IDXW'(0) + ($countones(hmap[head]));
  assign hdr_o    = req_o ? {ts[head], sp_addr_i, IDXW'(nhits - 1'b1)} : '0;
  assign lost_sum = {1'b0, lost_o} + (LOSTW+1)'($countones(drop));

  always_comb begin
    int k;
    payload_o = '0;
    k = 0;
    if (req_o) begin
      for (int p = 0; p < NPIX; p++) begin
        if (hmap[head][p]) begin
          payload_o[k*HITW +: HITW] = {IDXW'(p), tot[head][p]};
          k++;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      sync3  <= '0;
      valid  <= '0;
      open_b <= '0;
      head   <= 1'b0;
      tail   <= 1'b0;
      active <= '0;
      owner  <= '0;
      lost_o <= '0;
      for (int b = 0; b < 2; b++) begin
        ts[b]   <= '0;
        hmap[b] <= '0;
        for (int p = 0; p < NPIX; p++) tot[b][p] <= '0;
      end
    end else begin
      sync1 <= disc_i;
      sync2 <= sync1;
      sync3 <= sync2;

      for (int b = 0; b < 2; b++)
        if (open_b[b] && ts[b] != bxid_i) open_b[b] <= 1'b0;

      if (req_o && done_i) begin
        valid[head] <= 1'b0;
        head        <= ~head;
      end

      if (|accept) begin
        if (alloc) begin
          valid[tgt]  <= 1'b1;
          open_b[tgt] <= 1'b1;
          ts[tgt]     <= bxid_i;
          hmap[tgt]   <= accept;
          tail        <= ~tail;
        end else begin
          hmap[tgt] <= hmap[tgt] | accept;
        end
      end

      for (int p = 0; p < NPIX; p++) begin
        if (accept[p]) begin
          active[p]   <= 1'b1;
          owner[p]    <= tgt;
          tot[tgt][p] <= TOTW'(1);
        end else if (active[p]) begin
          if (sync2[p]) begin
            tot[owner[p]][p] <= tot[owner[p]][p] + 1'b1;
            if (tot[owner[p]][p] == TOT_MAX - 1'b1) active[p] <= 1'b0;
          end else begin
            active[p] <= 1'b0;
          end
        end
      end

      if (|drop) lost_o <= lost_sum[LOSTW] ? '1 : lost_sum[LOSTW-1:0];
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !done_i |=> req_o && $stable(hdr_o) && $stable(payload_o));

  // R9
  req_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && done_i |=> !req_o || hdr_o != $past(hdr_o));

  // R10
  lost_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o >= $past(lost_o));

  // R2
  first_tot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> payload_o[TOTW-1:0] != '0);

endmodule

// File: tb/superpixel_packetizer_tb.sv
module superpixel_packetizer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  disc = '0;
  logic [11:0]  bxid = '0;
  logic [11:0]  addr = 12'hA5C;
  logic         req;
  logic         done = 1'b0;
  logic [27:0]  hdr;
  logic [127:0] pay;
  logic [7:0]   lost;
  int n_tests = 0;
  int n_fail  = 0;

  superpixel_packetizer dut_i (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .bxid_i(bxid), .sp_addr_i(addr),
    .req_o(req), .done_i(done), .hdr_o(hdr), .payload_o(pay), .lost_o(lost));

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #2 bxid = bxid + 1'b1;
  end

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic wait_req(input string rq);
    int t;
    t = 0;
    while (!req && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(req, rq, 128'(req), 128'd1);
  endtask

  task automatic pulses(input int lens[16], output logic [11:0] ts);
    int mx;
    @(negedge clk);
    ts = bxid + 12'd2;
    mx = 0;
    for (int p = 0; p < 16; p++) begin
      if (lens[p] > 0) disc[p] = 1'b1;
      if (lens[p] > mx) mx = lens[p];
    end
    for (int c = 1; c <= mx; c++) begin
      @(negedge clk);
      for (int p = 0; p < 16; p++) if (lens[p] == c) disc[p] = 1'b0;
    end
  endtask

  task automatic check_pkt(input string rq, input logic [11:0] ts, input int lens[16]);
    logic [127:0] ep;
    int k;
    int t;
    ep = '0;
    k = 0;
    for (int p = 0; p < 16; p++) begin
      if (lens[p] > 0) begin
        t = lens[p] > 15 ? 15 : lens[p];
        ep[k*8 +: 8] = {4'(p), 4'(t)};
        k++;
      end
    end
    chk(hdr == {ts, addr, 4'(k - 1)}, {rq, " header"}, 128'(hdr), 128'({ts, addr, 4'(k - 1)}));
    chk(pay == ep, {rq, " payload"}, pay, ep);
  endtask

  task automatic t_reset();
    chk(!req && hdr == '0 && pay == '0, "R1 outputs idle", 128'({req, hdr}), 128'd0);
    chk(lost == 8'd0, "R1 lost count", 128'(lost), 128'd0);
  endtask

  task automatic t_single();
    int l[16];
    logic [11:0] ts;
    l = '{default: 0};
    l[5] = 3;
    pulses(l, ts);
    wait_req("R2 single request");
    check_pkt("R2 R4 R6 R7 single hit", ts, l);
    ack();
    cyc(1);
    chk(!req, "R9 freed on done", 128'(req), 128'd0);
  endtask

  task automatic t_group();
    int l[16];
    logic [11:0] ts;
    l = '{default: 0};
    l[15] = 12; l[0] = 2; l[9] = 1; l[3] = 7;
    pulses(l, ts);
    wait_req("R4 group request");
    check_pkt("R4 R7 grouped hits", ts, l);
    ack();
    cyc(20);
    chk(!req, "R4 single packet for group", 128'(req), 128'd0);
  endtask

  task automatic t_full();
    int l[16];
    logic [11:0] ts;
    for (int p = 0; p < 16; p++) l[p] = p + 1;
    pulses(l, ts);
    wait_req("R6 full request");
    check_pkt("R6 R7 sixteen hits", ts, l);
    chk(hdr[3:0] == 4'hF, "R6 count field", 128'(hdr[3:0]), 128'hF);
    ack();
  endtask

  task automatic t_sat();
    int l[16];
    logic [11:0] ts;
    l = '{default: 0};
    l[2] = 40;
    @(negedge clk);
    ts = bxid + 12'd2;
    disc[2] = 1'b1;
    cyc(25);
    chk(req && disc[2], "R3 request before fall", 128'({req, disc[2]}), 128'h3);
    check_pkt("R3 saturated charge", ts, l);
    ack();
    cyc(20);
    disc[2] = 1'b0;
    cyc(20);
    chk(!req, "R3 no packet from late fall", 128'(req), 128'd0);
  endtask

  task automatic t_wait_fall();
    int l[16];
    logic [11:0] ts;
    l = '{default: 0};
    l[7] = 12;
    @(negedge clk);
    ts = bxid + 12'd2;
    disc[7] = 1'b1;
    cyc(10);
    chk(!req, "R8 held while measuring", 128'(req), 128'd0);
    cyc(2);
    disc[7] = 1'b0;
    wait_req("R8 request after fall");
    check_pkt("R8 packet after fall", ts, l);
    ack();
  endtask

  task automatic t_sep_hold();
    int la[16];
    int lb[16];
    logic [11:0] ta, tb;
    logic [27:0] h0;
    la = '{default: 0};
    lb = '{default: 0};
    la[1] = 2;
    lb[4] = 2;
    @(negedge clk);
    ta = bxid + 12'd2;
    disc[1] = 1'b1;
    @(negedge clk);
    tb = bxid + 12'd2;
    disc[4] = 1'b1;
    @(negedge clk);
    disc[1] = 1'b0;
    @(negedge clk);
    disc[4] = 1'b0;
    wait_req("R5 first request");
    check_pkt("R5 oldest first", ta, la);
    h0 = hdr;
    cyc(6);
    chk(req && hdr == h0, "R9 request held", 128'({req, hdr}), 128'({1'b1, h0}));
    ack();
    wait_req("R5 second request");
    check_pkt("R5 second cluster", tb, lb);
    ack();
  endtask

  task automatic t_lost();
    int l0[16];
    int l1[16];
    logic [11:0] t0, t1;
    l0 = '{default: 0};
    l1 = '{default: 0};
    l0[0] = 1;
    l1[1] = 1;
    @(negedge clk);
    t0 = bxid + 12'd2;
    disc[0] = 1'b1;
    @(negedge clk);
    disc[0] = 1'b0;
    @(negedge clk);
    t1 = bxid + 12'd2;
    disc[1] = 1'b1;
    @(negedge clk);
    disc[1] = 1'b0;
    @(negedge clk);
    disc[2] = 1'b1;
    disc[3] = 1'b1;
    @(negedge clk);
    disc[2] = 1'b0;
    disc[3] = 1'b0;
    cyc(10);
    chk(lost == 8'd2, "R10 dropped edges counted", 128'(lost), 128'd2);
    wait_req("R10 first held");
    check_pkt("R10 first held cluster", t0, l0);
    ack();
    wait_req("R10 second held");
    check_pkt("R10 second held cluster", t1, l1);
    ack();
    cyc(20);
    chk(!req, "R10 dropped edges make no packet", 128'(req), 128'd0);
  endtask

  task automatic t_done_idle();
    int l[16];
    logic [11:0] ts;
    l = '{default: 0};
    l[6] = 8;
    ack();
    cyc(2);
    chk(!req && lost == 8'd2, "R9 idle done ignored", 128'({req, lost}), 128'd2);
    @(negedge clk);
    ts = bxid + 12'd2;
    disc[6] = 1'b1;
    cyc(4);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    cyc(3);
    disc[6] = 1'b0;
    wait_req("R9 pending cluster survives done");
    check_pkt("R9 pending cluster intact", ts, l);
    ack();
  endtask

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_single();
    t_group();
    t_full();
    t_sat();
    t_wait_fall();
    t_sep_hold();
    t_lost();
    t_done_idle();
    cyc(5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule